// File: doc/BRIEF.md
# Wormhole Packet Crossbar Switch

This block is a parameterized crossbar that moves variable-length packets from any of its input ports to any of its output ports using cut-through (wormhole) forwarding. Each input receives a stream of flits with a valid/ready handshake and an end-of-packet flag. Every flit also carries a sideband output number. An interval-routing selector upstream fills that number in, and the switch reads it only on the flit that acts as the packet's header. The routing decision is taken as soon as that header reaches the front of the input. From then on the chosen output is held as a temporary circuit until the tail flit has passed. Body flits stream straight through and are never gathered into a whole-packet store.

Each input has a two-flit skid buffer and signals backpressure through its ready line. When several inputs ask for the same free output in the same cycle, a round-robin arbiter for that output picks one of them. Inputs bound for different outputs proceed together. For two-phase routing, an input can be set to delete the leading flit of every packet. That flit is the outer, random-intermediate header. The flit behind it then routes the packet and is forwarded as its header.

Top module: `wh_xbar`

## Requirements
- R1: After reset every `in_ready` bit is 1 and every `out_valid` bit is 0.
- R2: An input accepts a flit while its buffer holds fewer than two flits. `in_ready` is 0 while it holds two, and nothing is lost or reordered.
- R3: The output is the binary number in `in_route` on the header flit (bits [PW-1:0] of the input's slice). Every flit of that packet leaves on that output in arrival order with unchanged data. The route field of non-header flits is ignored.
- R4: Once an output is granted to an input, it carries only that input's flits until the flit with `in_last`=1 has transferred.
- R5: An output is released in the cycle after its tail transfers. A header that is waiting can be granted at that same edge, so its first flit is offered no earlier than one cycle later. A header that enters an idle input is offered two cycles after it is accepted.
- R6: If several inputs request a free output in one cycle, the grant goes to the first requester after the last granted input, in ascending index order with wrap-around. After reset input 0 ranks first.
- R7: While `out_valid` is 1 and `out_ready` is 0, the output keeps `out_valid` high and `out_data` unchanged.
- R8: Input/output pairs that share neither end transfer in the same cycles, so all outputs can be valid together.
- R9: With `strip_en[i]`=1, the first flit of each packet on input i appears on no output. The next flit supplies the route and leaves as the header. A one-flit packet on such an input is dropped whole.
- R10: With `strip_en[i]`=0, the first flit of each packet is the header and is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strip_en | input | NP | Per input: delete the leading flit of each packet |
| in_valid | input | NP | Per input flit valid |
| in_data | input | NP*DW | Per input flit payload |
| in_last | input | NP | Per input tail-flit flag |
| in_route | input | NP*PW | Per input output number, used on header flits |
| in_ready | output | NP | Per input buffer ready |
| out_valid | output | NP | Per output flit valid |
| out_data | output | NP*DW | Per output flit payload |
| out_last | output | NP | Per output tail-flit flag |
| out_ready | input | NP | Per output sink ready |

## Verification
A lost or duplicated buffer entry shows up in the same cycle as a wrong `in_ready`, and at the latest one cycle later as wrong `out_data`. A stale owner or circuit register shows at once, as a flit from the wrong input or a missing `out_valid`. A release that comes too early or too late moves the start of the next packet by a cycle, which a model compared on every clock catches on that cycle. Arbitration pointer errors surface as a changed packet order on a contended output. Header-deletion faults surface as an outer flit appearing at an output, or as a packet count that does not match.

// File: rtl/wh_pkg.sv
package wh_pkg;
  // Per-input packet position
  typedef enum logic [1:0] {
    IN_HEAD  = 2'd0,  // next flit starts a packet
    IN_ROUTE = 2'd1,  // outer header deleted, next flit routes
    IN_BODY  = 2'd2   // circuit held to an output
  } in_state_e;
endpackage

// File: rtl/wh_skid.sv
module wh_skid #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  input  logic [W-1:0] push_data,
  output logic         push_ready,
  input  logic         pop,
  output logic         head_valid,
  output logic [W-1:0] head_data
);
  logic [1:0]   cnt_q, cnt_d;
  logic [W-1:0] ent0_q, ent0_d, ent1_q, ent1_d;
  logic         ent0_en, ent1_en, cnt_en;
  logic         do_push, do_pop;

  assign push_ready = (cnt_q != 2'd2);
  assign head_valid = (cnt_q != 2'd0);
  assign head_data  = ent0_q;
  assign do_push    = push_valid & push_ready;
  assign do_pop     = pop & head_valid;
  assign cnt_en     = do_push ^ do_pop;

  always_comb begin
    cnt_d   = cnt_q;
    ent0_d  = ent0_q;
    ent1_d  = ent1_q;
    ent0_en = 1'b0;
    ent1_en = 1'b0;
    case ({do_push, do_pop})
      2'b10: begin
        cnt_d = cnt_q + 2'd1;
        if (cnt_q == 2'd0) begin
          ent0_d  = push_data;
          ent0_en = 1'b1;
        end else begin
          ent1_d  = push_data;
          ent1_en = 1'b1;
        end
      end
      2'b01: begin
        cnt_d   = cnt_q - 2'd1;
        ent0_d  = ent1_q;
        ent0_en = 1'b1;
      end
      2'b11: begin
        ent0_d  = push_data;  // only reachable with one entry held
        ent0_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= 2'd0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (ent0_en) ent0_q <= ent0_d;
    if (ent1_en) ent1_q <= ent1_d;
  end

  // R2: a full buffer with no pop keeps its head flit
  p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == 2'd2 && !pop) |=> (cnt_q == 2'd2 && $stable(ent0_q)));
endmodule

// File: rtl/wh_rr_arb.sv
module wh_rr_arb #(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  logic [IW-1:0] ptr_q;
  int            cand;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    cand    = 0;
    for (int k = 1; k <= N; k++) begin
      cand = (int'(ptr_q) + k) % N;
      if (!gnt_any && en && req[IW'(cand)]) begin
        gnt_any            = 1'b1;
        gnt_idx            = IW'(cand);
        gnt[IW'(cand)]     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= IW'(N - 1);
    else if (gnt_any) ptr_q <= gnt_idx;
  end

  // R6: a grant only ever goes to a requester
  p_grant_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_any |-> ((gnt & req) != '0));
endmodule

// File: rtl/wh_xbar.sv
module wh_xbar
  import wh_pkg::*;
#(
  parameter  int NP = 4,
  parameter  int DW = 16,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1,
  localparam int FW = DW + 1 + PW
) (
  input  logic [0:0]       clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    strip_en,
  input  logic [NP-1:0]    in_valid,
  input  logic [NP*DW-1:0] in_data,
  input  logic [NP-1:0]    in_last,
  input  logic [NP*PW-1:0] in_route,
  output logic [NP-1:0]    in_ready,
  output logic [NP-1:0]    out_valid,
  output logic [NP*DW-1:0] out_data,
  output logic [NP-1:0]    out_last,
  input  logic [NP-1:0]    out_ready
);
  // reset: asserted at once, released two edges later
  logic rst_s1_q, rst_s2_q, rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int = rst_s2_q;

  // input side
  logic [DW-1:0] hd_data  [NP];
  logic [PW-1:0] hd_route [NP];
  logic [NP-1:0] hd_valid, hd_last;
  logic [NP-1:0] want, drop, fwd, pop, in_en;
  in_state_e     st_q [NP], st_d [NP];
  logic [PW-1:0] conn_q [NP], conn_d [NP];
  logic [NP-1:0] g_hit;
  logic [PW-1:0] g_port [NP];

  // output side
  logic [NP-1:0] busy_q, busy_d, out_en, tail_x, gany;
  logic [PW-1:0] owner_q [NP], owner_d [NP], gidx [NP];
  logic [NP-1:0] req_m [NP], gnt_m [NP];

  for (genvar gi = 0; gi < NP; gi++) begin : g_in
    logic [FW-1:0] head;
    logic [NP-1:0] own_by;

    wh_skid #(.W(FW)) u_skid (
      .clk       (clk),
      .rst_n     (rst_int),
      .push_valid(in_valid[gi]),
      .push_data ({in_route[gi*PW +: PW], in_last[gi], in_data[gi*DW +: DW]}),
      .push_ready(in_ready[gi]),
      .pop       (pop[gi]),
      .head_valid(hd_valid[gi]),
      .head_data (head)
    );
    assign hd_data[gi]  = head[DW-1:0];
    assign hd_last[gi]  = head[DW];
    assign hd_route[gi] = head[FW-1 -: PW];

    always_comb begin
      for (int o = 0; o < NP; o++) own_by[o] = busy_q[o] && (owner_q[o] == PW'(gi));
    end

    // R8: an input holds at most one output at a time
    p_one_out_r8: assert property (@(posedge clk) disable iff (!rst_int)
      $countones(own_by) <= 1);
    // R4: an input streaming a body owns the output it is bound to
    p_body_owned_r4: assert property (@(posedge clk) disable iff (!rst_int)
      (st_q[gi] == IN_BODY) |-> (busy_q[conn_q[gi]] && owner_q[conn_q[gi]] == PW'(gi)));
  end

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      want[i] = hd_valid[i] && ((st_q[i] == IN_ROUTE) || (st_q[i] == IN_HEAD && !strip_en[i]));
      drop[i] = hd_valid[i] && (st_q[i] == IN_HEAD) && strip_en[i];
      fwd[i]  = hd_valid[i] && (st_q[i] == IN_BODY) && out_ready[conn_q[i]];
      pop[i]  = drop[i] | fwd[i];
    end
  end

  always_comb begin
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++)
        req_m[o][i] = want[i] && (hd_route[i] == PW'(o));
  end

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      g_hit[i]  = 1'b0;
      g_port[i] = '0;
      for (int o = 0; o < NP; o++) begin
        if (gnt_m[o][i]) begin
          g_hit[i]  = 1'b1;
          g_port[i] = PW'(o);
        end
      end
    end
  end

  // input next state
  always_comb begin
    for (int i = 0; i < NP; i++) begin
      st_d[i]   = st_q[i];
      conn_d[i] = conn_q[i];
      case (st_q[i])
        IN_HEAD: begin
          if (drop[i]) st_d[i] = hd_last[i] ? IN_HEAD : IN_ROUTE;
          else if (g_hit[i]) begin
            st_d[i]   = IN_BODY;
            conn_d[i] = g_port[i];
          end
        end
        IN_ROUTE: begin
          if (g_hit[i]) begin
            st_d[i]   = IN_BODY;
            conn_d[i] = g_port[i];
          end
        end
        IN_BODY: if (fwd[i] && hd_last[i]) st_d[i] = IN_HEAD;
        default: st_d[i] = IN_HEAD;
      endcase
      in_en[i] = drop[i] | g_hit[i] | (fwd[i] & hd_last[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      for (int i = 0; i < NP; i++) begin
        st_q[i]   <= IN_HEAD;
        conn_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (in_en[i]) begin
          st_q[i]   <= st_d[i];
          conn_q[i] <= conn_d[i];
        end
      end
    end
  end

  // output next state
  always_comb begin
    for (int o = 0; o < NP; o++) begin
      busy_d[o]  = busy_q[o];
      owner_d[o] = owner_q[o];
      if (tail_x[o]) busy_d[o] = 1'b0;
      else if (gany[o]) begin
        busy_d[o]  = 1'b1;
        owner_d[o] = gidx[o];
      end
      out_en[o] = tail_x[o] | gany[o];
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      busy_q <= '0;
      for (int o = 0; o < NP; o++) owner_q[o] <= '0;
    end else begin
      for (int o = 0; o < NP; o++) begin
        if (out_en[o]) begin
          busy_q[o]  <= busy_d[o];
          owner_q[o] <= owner_d[o];
        end
      end
    end
  end

  for (genvar go = 0; go < NP; go++) begin : g_out
    assign out_valid[go]          = busy_q[go] & hd_valid[owner_q[go]];
    assign out_last[go]           = busy_q[go] & hd_last[owner_q[go]];
    assign out_data[go*DW +: DW]  = hd_data[owner_q[go]];
    assign tail_x[go]             = out_valid[go] & out_ready[go] & out_last[go];

    wh_rr_arb #(.N(NP)) u_arb (
      .clk    (clk),
      .rst_n  (rst_int),
      .en     (!busy_q[go]),
      .req    (req_m[go]),
      .gnt    (gnt_m[go]),
      .gnt_idx(gidx[go]),
      .gnt_any(gany[go])
    );

    // R4: owner stays put until the tail transfers
    p_owner_hold_r4: assert property (@(posedge clk) disable iff (!rst_int)
      (busy_q[go] && !tail_x[go]) |=> (busy_q[go] && owner_q[go] == $past(owner_q[go])));
    // R5: the output is free right after its tail
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_int)
      tail_x[go] |=> !busy_q[go]);
    // R7: a stalled flit stays on the output
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_int)
      (out_valid[go] && !out_ready[go]) |=> (out_valid[go] && $stable(out_data[go*DW +: DW])));
  end
endmodule

// File: tb/wh_xbar_test.sv
`timescale 1ns/1ps
module wh_xbar_test;
  localparam int NP = 4;
  localparam int DW = 16;
  localparam int PW = 2;
  localparam int FW = DW + 1 + PW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic [NP-1:0]     strip_en, in_valid, in_last, out_ready;
  logic [NP*DW-1:0]  in_data;
  logic [NP*PW-1:0]  in_route;
  logic [NP-1:0]     in_ready, out_valid, out_last;
  logic [NP*DW-1:0]  out_data;

  wh_xbar #(.NP(NP), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .strip_en(strip_en), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_route(in_route), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [FW-1:0] src [NP][$];
  logic [FW-1:0] mq  [NP][$];
  int  st [NP], conn [NP], owner [NP], ptr [NP];
  bit  busy [NP];
  int  tails [NP], exp_tails [NP];
  bit  sop [NP];
  int  first_src [$];
  bit  all_valid_seen, saw_outer;
  bit  gate_rand, rand_ready;
  logic [NP-1:0] hold_mask;
  logic [15:0] lfsr;
  int  seq;
  logic [DW-1:0] last_hdr;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NP; i++) begin
      src[i].delete();
      mq[i].delete();
      st[i] = 0; conn[i] = 0; owner[i] = 0; ptr[i] = NP - 1; busy[i] = 1'b0;
      tails[i] = 0; exp_tails[i] = 0; sop[i] = 1'b1;
    end
    first_src.delete();
    all_valid_seen = 1'b0;
    saw_outer = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = '0; in_data = '0; in_last = '0; in_route = '0; out_ready = '0;
    hold_mask = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_reset();
  endtask

  task automatic add_pkt(input int i, input int dst, input int len, input bit outer);
    if (outer) begin
      src[i].push_back({PW'(dst ^ 1), 1'b0, 16'hE000 | 16'(seq & 'hFFF)});
      seq++;
    end
    for (int n = 0; n < len; n++) begin
      if (n == 0) last_hdr = {4'(i), 12'(seq)};
      src[i].push_back({PW'(dst), (n == len - 1), 4'(i), 12'(seq)});
      seq++;
    end
    exp_tails[dst]++;
  endtask

  task automatic add_drop(input int i);
    src[i].push_back({PW'(2), 1'b1, 16'hE000 | 16'(seq & 'hFFF)});
    seq++;
  endtask

  // one clock: drive at the falling edge, compare, advance the model
  task automatic step();
    int  gnt_o [NP];
    int  g_in [NP];
    bit  hv [NP], want [NP], spop [NP], fpop [NP], push [NP], tail [NP], lastf [NP];
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    for (int i = 0; i < NP; i++) begin
      logic [FW-1:0] f;
      f = (src[i].size() > 0) ? src[i][0] : '0;
      in_valid[i] = (src[i].size() > 0) && (!gate_rand || lfsr[i]);
      in_data[i*DW +: DW] = f[DW-1:0];
      in_last[i] = f[DW];
      in_route[i*PW +: PW] = f[FW-1 -: PW];
      out_ready[i] = (!rand_ready || lfsr[i+5]) && !hold_mask[i];
    end
    #1;
    for (int i = 0; i < NP; i++)
      chk(in_ready[i] == (mq[i].size() < 2), "R2", "in_ready", in_ready[i], mq[i].size() < 2);
    for (int o = 0; o < NP; o++) begin
      bit ev;
      ev = busy[o] && (mq[owner[o]].size() > 0);
      chk(out_valid[o] == ev, "R4", "out_valid", out_valid[o], ev);
      if (ev) begin
        chk(out_data[o*DW +: DW] == mq[owner[o]][0][DW-1:0], "R3", "out_data",
            out_data[o*DW +: DW], mq[owner[o]][0][DW-1:0]);
        chk(out_last[o] == mq[owner[o]][0][DW], "R5", "out_last", out_last[o], mq[owner[o]][0][DW]);
      end
    end
    // port observation
    if (&out_valid) all_valid_seen = 1'b1;
    for (int o = 0; o < NP; o++) begin
      if (out_valid[o] && out_ready[o]) begin
        if (out_data[o*DW+12 +: 4] == 4'hE) saw_outer = 1'b1;
        if (sop[o] && o == 2) first_src.push_back(int'(out_data[o*DW+12 +: 4]));
        sop[o] = out_last[o];
        if (out_last[o]) tails[o]++;
      end
    end
    // reference model
    for (int i = 0; i < NP; i++) begin
      hv[i]    = mq[i].size() > 0;
      lastf[i] = hv[i] ? mq[i][0][DW] : 1'b0;
      want[i]  = hv[i] && (st[i] == 1 || (st[i] == 0 && !strip_en[i]));
      spop[i]  = hv[i] && st[i] == 0 && strip_en[i];
      fpop[i]  = hv[i] && st[i] == 2 && out_ready[conn[i]];
      push[i]  = in_valid[i] && mq[i].size() < 2;
      g_in[i]  = -1;
    end
    for (int o = 0; o < NP; o++) begin
      gnt_o[o] = -1;
      tail[o]  = busy[o] && hv[owner[o]] && out_ready[o] && lastf[owner[o]];
      if (!busy[o]) begin
        for (int k = 1; k <= NP; k++) begin
          int c;
          c = (ptr[o] + k) % NP;
          if (gnt_o[o] < 0 && want[c] && int'(mq[c][0][FW-1 -: PW]) == o) begin
            gnt_o[o] = c;
            g_in[c] = o;
          end
        end
      end
    end
    for (int o = 0; o < NP; o++) begin
      if (tail[o]) busy[o] = 1'b0;
      else if (gnt_o[o] >= 0) begin
        busy[o] = 1'b1; owner[o] = gnt_o[o]; ptr[o] = gnt_o[o];
      end
    end
    for (int i = 0; i < NP; i++) begin
      case (st[i])
        0: if (spop[i]) st[i] = lastf[i] ? 0 : 1;
           else if (g_in[i] >= 0) begin st[i] = 2; conn[i] = g_in[i]; end
        1: if (g_in[i] >= 0) begin st[i] = 2; conn[i] = g_in[i]; end
        default: if (fpop[i] && lastf[i]) st[i] = 0;
      endcase
      if (spop[i] || fpop[i]) void'(mq[i].pop_front());
      if (push[i]) mq[i].push_back(src[i].pop_front());
    end
    @(negedge clk);
  endtask

  task automatic run_idle(input int cap);
    bit idle;
    for (int n = 0; n < cap; n++) begin
      idle = 1'b1;
      for (int i = 0; i < NP; i++)
        if (src[i].size() > 0 || mq[i].size() > 0 || st[i] != 0 || busy[i]) idle = 1'b0;
      if (idle) break;
      step();
    end
  endtask

  task automatic chk_tails(input string tag);
    for (int o = 0; o < NP; o++)
      chk(tails[o] == exp_tails[o], tag, "packets delivered", tails[o], exp_tails[o]);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    lfsr = 16'hACE1; seq = 0; gate_rand = 1'b0; rand_ready = 1'b0; strip_en = '0;
    do_reset();

    // R1: reset state
    chk(in_ready == '1, "R1", "in_ready after reset", in_ready, 4'hF);
    chk(out_valid == '0, "R1", "out_valid after reset", out_valid, 0);

    // R8: four disjoint circuits at once
    for (int i = 0; i < NP; i++) add_pkt(i, (i + 1) % NP, 4, 1'b0);
    run_idle(200);
    chk(all_valid_seen, "R8", "all outputs valid together", all_valid_seen, 1);
    chk_tails("R3");

    // R6: contention on output 2, then wrap-around
    do_reset();
    for (int i = 0; i < NP; i++) add_pkt(i, 2, 2, 1'b0);
    run_idle(200);
    add_pkt(3, 2, 2, 1'b0);
    add_pkt(1, 2, 2, 1'b0);
    run_idle(200);
    chk(first_src.size() == 6, "R6", "packet count on out2", first_src.size(), 6);
    if (first_src.size() == 6) begin
      chk(first_src[0] == 0, "R6", "order[0]", first_src[0], 0);
      chk(first_src[1] == 1, "R6", "order[1]", first_src[1], 1);
      chk(first_src[2] == 2, "R6", "order[2]", first_src[2], 2);
      chk(first_src[3] == 3, "R6", "order[3]", first_src[3], 3);
      chk(first_src[4] == 1, "R6", "order[4] wrap", first_src[4], 1);
      chk(first_src[5] == 3, "R6", "order[5] wrap", first_src[5], 3);
    end

    // R2 and R7: blocked output fills the input buffer
    hold_mask = 4'b0001;
    add_pkt(1, 0, 5, 1'b0);
    repeat (8) step();
    chk(in_ready[1] == 1'b0, "R2", "in_ready with two held", in_ready[1], 0);
    chk(out_valid[0] == 1'b1, "R7", "out_valid while stalled", out_valid[0], 1);
    held = out_data[DW-1:0];
    chk(held == last_hdr, "R7", "stalled header data", held, last_hdr);
    repeat (3) step();
    chk(out_data[DW-1:0] == held, "R7", "data stable in stall", out_data[DW-1:0], held);
    hold_mask = '0;
    run_idle(200);

    // R4/R5: random traffic and random backpressure
    do_reset();
    gate_rand = 1'b1; rand_ready = 1'b1;
    for (int n = 0; n < 15; n++)
      for (int i = 0; i < NP; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        add_pkt(i, int'(lfsr[1:0]), 1 + int'(lfsr[7:4]) % 5, 1'b0);
      end
    run_idle(20000);
    chk_tails("R4");

    // R9/R10: header deletion on inputs 0 and 2
    do_reset();
    strip_en = 4'b0101;
    add_pkt(0, 3, 3, 1'b1);
    add_drop(0);
    add_pkt(0, 1, 1, 1'b1);
    add_pkt(1, 2, 3, 1'b0);
    add_pkt(2, 0, 2, 1'b1);
    add_drop(2);
    add_pkt(3, 2, 1, 1'b0);
    run_idle(2000);
    chk(!saw_outer, "R9", "outer header reached an output", saw_outer, 0);
    chk_tails("R9");
    chk(tails[2] == 2, "R10", "unstripped packets on out2", tails[2], 2);
    strip_en = '0;
    gate_rand = 1'b0; rand_ready = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule